// File: doc/BRIEF.md
# Binary Synchronous Receive Frame Parser

This block sits behind a character-synchronised receiver. It takes one received character per strobe. It works out where that character sits in a binary synchronous frame: idle, header, plain text, transparent text, block-check characters or trailing fill. For each character it decides whether the character goes to the receive buffer, and whether the external CRC accumulator should include it. It marks the block-check characters. When the frame finishes, it reports a completion code together with a CRC-checker reset and a request to resynchronise.

The control character values are inputs to the block, so the same logic can serve an ASCII or an EBCDIC link. SYN fill is removed in the header and in plain text. In transparent text only the escape character is examined. An escape pair either carries a literal escape, removes a fill pair, or ends the block. Intermediate checks return the parser to whichever text mode was active before them. Every result appears on registered outputs in the clock cycle after the strobe.

Top module: `bsc_rx_parser`

## Requirements
- R1: After reset all output strobes are low. In idle, SYN characters are dropped. A first STX, SOH or DLE is stored with `out_crc_en` low, and any other first character not named in R2 is stored with `out_crc_en` low while the parser stays idle.
- R2: A first NAK, ENQ or BEL ends the frame with code 0x80, and so does a first EOT when `cfg_eot_hunt` is 0. With `cfg_eot_hunt` at 1, a first EOT is stored and pulses `hunt_req` without `frame_end`.
- R3: In header and plain text (including right after an intermediate check), a SYN is neither stored nor counted in the CRC.
- R4: Any other character in header or plain text is stored unchanged with `out_crc_en` high.
- R5: After ETX or ETB, the next two characters are stored with `out_chk` and `out_crc_en` high. The two characters after those are dropped. The second of them ends the frame with code 0x80, or 0xC0 if `crc_err_in` is high while it arrives.
- R6: ENQ in plain text ends the frame with code 0x80.
- R7: In transparent text every character except DLE, SYN included, is stored with `out_crc_en` high. A lone DLE produces no output.
- R8: After a transparent DLE: a SYN drops the pair; a DLE stores one DLE; ETX, ETB or ITB is stored and starts its check; ENQ ends the frame with 0x80; anything else ends the frame with code 0x08.
- R9: A frame-opening DLE followed by anything but STX ends the frame with 0x80. A DLE inside a header followed by anything but STX ends the frame with 0x08. DLE STX enters transparent text.
- R10: ITB is followed by two stored check characters. If the text was plain, SYNs are dropped and plain text resumes. If it was transparent, SYNs are dropped and only DLE STX is accepted; any other character ends the frame with 0x08.
- R11: Every frame end pulses `frame_end`, `crc_reset` and `hunt_req` in the same cycle, with `out_crc_en` low, and the next frame starts from idle.
- R12: Control values come from the `cfg_*` inputs. With SYN remapped, the old SYN value is ordinary data and the new value is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Character strobe |
| rx_char | input | 8 | Received character |
| cfg_syn | input | 8 | SYN value |
| cfg_dle | input | 8 | DLE value |
| cfg_stx | input | 8 | STX value |
| cfg_soh | input | 8 | SOH value |
| cfg_etx | input | 8 | ETX value |
| cfg_etb | input | 8 | ETB value |
| cfg_itb | input | 8 | ITB value |
| cfg_enq | input | 8 | ENQ value |
| cfg_nak | input | 8 | NAK value |
| cfg_eot | input | 8 | EOT value |
| cfg_bel | input | 8 | BEL value |
| cfg_eot_hunt | input | 1 | First EOT requests hunt instead of ending the frame |
| crc_err_in | input | 1 | CRC checker error flag, sampled on the last fill |
| out_valid | output | 1 | Character stored this cycle |
| out_char | output | 8 | Stored character (zero when not valid) |
| out_crc_en | output | 1 | Stored character is counted in the CRC |
| out_chk | output | 1 | Stored character is a block-check character |
| frame_end | output | 1 | Frame completion strobe |
| frame_code | output | 8 | Completion code, valid with `frame_end` |
| hunt_req | output | 1 | Request to return to hunt mode |
| crc_reset | output | 1 | CRC checker reset pulse |

## Verification
The assertions assume that the eleven configured control values are distinct. When values collide, the lowest-ranked class wins the decode and the frame rules no longer apply. They also assume that `rx_valid` lasts one cycle per character. The stimulus uses one fixed, collision-free table, except that SYN is remapped to a value that clashes with no other code. It drives every strobe for exactly one cycle with idle cycles in between. The sweeps push every byte value through plain and transparent text. They skip only the values that the requirement under test names as controls in that mode.

// File: rtl/bsc_rx_pkg.sv
package bsc_rx_pkg;
  localparam int NCODE = 11;

  typedef enum logic [4:0] {
    ST_IDLE, ST_HDR_START, ST_HDR, ST_NT_START, ST_NT,
    ST_DLE_FIRST, ST_DLE_IN, ST_T_DATA, ST_T_ESC,
    ST_ITB_C1, ST_ITB_C2, ST_ITB_NT, ST_ITB_T,
    ST_END_C1, ST_END_C2, ST_FILL1, ST_FILL2
  } state_t;

  // Order matches the packed code vector built in the top (index + 1).
  typedef enum logic [3:0] {
    CC_DATA, CC_SYN, CC_DLE, CC_STX, CC_SOH, CC_ETX,
    CC_ETB, CC_ITB, CC_ENQ, CC_NAK, CC_EOT, CC_BEL
  } cclass_t;

  localparam logic [7:0] CODE_DONE    = 8'h80;
  localparam logic [7:0] CODE_CRC_BAD = 8'h40;
  localparam logic [7:0] CODE_ILLEGAL = 8'h08;
endpackage

// File: rtl/bsc_rx_classify.sv
module bsc_rx_classify
  import bsc_rx_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic [CW-1:0]       ch,
  input  logic [NCODE*CW-1:0] codes,
  output cclass_t             cls
);
  logic [NCODE-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NCODE; g++) begin : g_cmp
      assign hit[g] = (ch == codes[g*CW +: CW]);
    end
  endgenerate

  // Lowest index wins when configured values collide.
  always_comb begin
    cls = CC_DATA;
    for (int i = NCODE - 1; i >= 0; i--) begin
      if (hit[i]) cls = cclass_t'(4'(i + 1));
    end
  end
endmodule

// File: rtl/bsc_rx_fsm.sv
module bsc_rx_fsm
  import bsc_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       valid,
  input  cclass_t    cls,
  input  logic       eot_hunt,
  input  logic       crc_err,
  output logic       d_store,
  output logic       d_crc,
  output logic       d_chk,
  output logic       d_fin,
  output logic       d_hunt,
  output logic [7:0] d_code
);
  state_t st, nxt;
  logic   tflag, tflag_nxt;
  logic   hdr_path, nt_path;

  always_comb begin
    nxt      = st;
    d_store  = 1'b0;
    d_crc    = 1'b0;
    d_chk    = 1'b0;
    d_fin    = 1'b0;
    d_hunt   = 1'b0;
    d_code   = 8'h00;
    hdr_path = 1'b0;
    nt_path  = 1'b0;
    if (valid) begin
      case (st)
        ST_IDLE: begin
          case (cls)
            CC_SYN: ;
            CC_STX: begin d_store = 1'b1; nxt = ST_NT_START; end
            CC_SOH: begin d_store = 1'b1; nxt = ST_HDR_START; end
            CC_DLE: begin d_store = 1'b1; nxt = ST_DLE_FIRST; end
            CC_EOT: begin
              d_store = 1'b1;
              if (eot_hunt) d_hunt = 1'b1;
              else begin d_fin = 1'b1; d_code = CODE_DONE; end
            end
            CC_NAK, CC_ENQ, CC_BEL: begin
              d_store = 1'b1; d_fin = 1'b1; d_code = CODE_DONE;
            end
            default: d_store = 1'b1;
          endcase
        end
        ST_HDR_START, ST_HDR: begin
          if (cls == CC_SYN) nxt = ST_HDR_START;
          else hdr_path = 1'b1;
        end
        ST_NT_START, ST_NT, ST_ITB_NT: begin
          if (cls == CC_SYN) nxt = ST_NT_START;
          else nt_path = 1'b1;
        end
        ST_DLE_FIRST: begin
          d_store = 1'b1;
          if (cls == CC_STX) nxt = ST_T_DATA;
          else begin d_fin = 1'b1; d_code = CODE_DONE; end
        end
        ST_DLE_IN: begin
          d_store = 1'b1;
          if (cls == CC_STX) begin d_crc = 1'b1; nxt = ST_T_DATA; end
          else begin d_fin = 1'b1; d_code = CODE_ILLEGAL; end
        end
        ST_T_DATA: begin
          if (cls == CC_DLE) nxt = ST_T_ESC;
          else begin d_store = 1'b1; d_crc = 1'b1; end
        end
        ST_T_ESC: begin
          case (cls)
            CC_SYN: nxt = ST_T_DATA;
            CC_DLE: begin d_store = 1'b1; d_crc = 1'b1; nxt = ST_T_DATA; end
            CC_ETX, CC_ETB: begin d_store = 1'b1; d_crc = 1'b1; nxt = ST_END_C1; end
            CC_ITB: begin d_store = 1'b1; d_crc = 1'b1; nxt = ST_ITB_C1; end
            CC_ENQ: begin d_store = 1'b1; d_fin = 1'b1; d_code = CODE_DONE; end
            default: begin d_store = 1'b1; d_fin = 1'b1; d_code = CODE_ILLEGAL; end
          endcase
        end
        ST_ITB_C1: begin
          d_store = 1'b1; d_crc = 1'b1; d_chk = 1'b1; nxt = ST_ITB_C2;
        end
        ST_ITB_C2: begin
          d_store = 1'b1; d_crc = 1'b1; d_chk = 1'b1;
          nxt = tflag ? ST_ITB_T : ST_ITB_NT;
        end
        ST_ITB_T: begin
          case (cls)
            CC_SYN: ;
            CC_DLE: begin d_store = 1'b1; d_crc = 1'b1; nxt = ST_DLE_IN; end
            default: begin d_store = 1'b1; d_fin = 1'b1; d_code = CODE_ILLEGAL; end
          endcase
        end
        ST_END_C1: begin
          d_store = 1'b1; d_crc = 1'b1; d_chk = 1'b1; nxt = ST_END_C2;
        end
        ST_END_C2: begin
          d_store = 1'b1; d_crc = 1'b1; d_chk = 1'b1; nxt = ST_FILL1;
        end
        ST_FILL1: nxt = ST_FILL2;
        ST_FILL2: begin
          d_fin  = 1'b1;
          d_code = CODE_DONE | (crc_err ? CODE_CRC_BAD : 8'h00);
        end
        default: nxt = ST_IDLE;
      endcase

      if (hdr_path) begin
        d_store = 1'b1; d_crc = 1'b1;
        case (cls)
          CC_STX:         nxt = ST_NT;
          CC_DLE:         nxt = ST_DLE_IN;
          CC_ETX, CC_ETB: nxt = ST_END_C1;
          default:        nxt = ST_HDR;
        endcase
      end

      if (nt_path) begin
        d_store = 1'b1; d_crc = 1'b1;
        case (cls)
          CC_ETX, CC_ETB: nxt = ST_END_C1;
          CC_ITB:         nxt = ST_ITB_C1;
          CC_ENQ:         begin d_fin = 1'b1; d_code = CODE_DONE; end
          default:        nxt = ST_NT;
        endcase
      end

      if (d_fin) begin
        nxt    = ST_IDLE;
        d_hunt = 1'b1;
        d_crc  = 1'b1 & ~d_fin;
      end
    end
  end

  always_comb begin
    tflag_nxt = tflag;
    if (d_fin || nxt == ST_END_C1) tflag_nxt = 1'b0;
    else if (nxt == ST_T_DATA)     tflag_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      tflag <= 1'b0;
    end else begin
      st    <= nxt;
      tflag <= tflag_nxt;
    end
  end

  // R7: the escape state is only reachable from transparent text.
  a_r7_esc_is_transparent: assert property (@(posedge clk) disable iff (rst)
    (st == ST_T_ESC) |-> tflag);
  // R10: the post-ITB transparent wait needs the transparent flag.
  a_r10_itb_keeps_mode: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ITB_T) |-> tflag);
  // R5: the ending check characters are followed by the fill pair.
  a_r5_chk_then_fill: assert property (@(posedge clk) disable iff (rst)
    (st == ST_END_C2 && valid) |=> (st == ST_FILL1));
  // R11: a finished frame always restarts from idle with the flag clear.
  a_r11_back_to_idle: assert property (@(posedge clk) disable iff (rst)
    d_fin |=> (st == ST_IDLE && !tflag));
endmodule

// File: rtl/bsc_rx_outreg.sv
module bsc_rx_outreg #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic [CW-1:0] ch,
  input  logic          d_store,
  input  logic          d_crc,
  input  logic          d_chk,
  input  logic          d_fin,
  input  logic          d_hunt,
  input  logic [7:0]    d_code,
  output logic          out_valid,
  output logic [CW-1:0] out_char,
  output logic          out_crc_en,
  output logic          out_chk,
  output logic          frame_end,
  output logic [7:0]    frame_code,
  output logic          hunt_req,
  output logic          crc_reset
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_char   <= '0;
      out_crc_en <= 1'b0;
      out_chk    <= 1'b0;
      frame_end  <= 1'b0;
      frame_code <= 8'h00;
      hunt_req   <= 1'b0;
      crc_reset  <= 1'b0;
    end else begin
      out_valid  <= d_store;
      out_char   <= d_store ? ch : '0;
      out_crc_en <= d_store & d_crc & ~d_fin;
      out_chk    <= d_chk;
      frame_end  <= d_fin;
      frame_code <= d_fin ? d_code : 8'h00;
      hunt_req   <= d_hunt;
      crc_reset  <= d_fin;
    end
  end

  // R5: a check character is always a stored character counted in the CRC.
  a_r5_chk_stored: assert property (@(posedge clk) disable iff (rst)
    out_chk |-> (out_valid && out_crc_en));
  // R11: every frame end comes with a hunt request.
  a_r11_end_hunts: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> (hunt_req && crc_reset && !out_crc_en));
  // R8: completion codes are limited to the defined set.
  a_r8_code_set: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> (frame_code == 8'h80 || frame_code == 8'hC0 || frame_code == 8'h08));
  // R1: no output activity without a character strobe one cycle earlier.
  a_r1_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    (out_valid || frame_end || hunt_req) |-> $past(valid));
endmodule

// File: rtl/bsc_rx_parser.sv
module bsc_rx_parser
  import bsc_rx_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_char,
  input  logic [CW-1:0] cfg_syn,
  input  logic [CW-1:0] cfg_dle,
  input  logic [CW-1:0] cfg_stx,
  input  logic [CW-1:0] cfg_soh,
  input  logic [CW-1:0] cfg_etx,
  input  logic [CW-1:0] cfg_etb,
  input  logic [CW-1:0] cfg_itb,
  input  logic [CW-1:0] cfg_enq,
  input  logic [CW-1:0] cfg_nak,
  input  logic [CW-1:0] cfg_eot,
  input  logic [CW-1:0] cfg_bel,
  input  logic          cfg_eot_hunt,
  input  logic          crc_err_in,
  output logic          out_valid,
  output logic [CW-1:0] out_char,
  output logic          out_crc_en,
  output logic          out_chk,
  output logic          frame_end,
  output logic [7:0]    frame_code,
  output logic          hunt_req,
  output logic          crc_reset
);
  logic [NCODE*CW-1:0] codes;
  cclass_t             cls;
  logic                d_store, d_crc, d_chk, d_fin, d_hunt;
  logic [7:0]          d_code;

  assign codes = {cfg_bel, cfg_eot, cfg_nak, cfg_enq, cfg_itb, cfg_etb,
                  cfg_etx, cfg_soh, cfg_stx, cfg_dle, cfg_syn};

  bsc_rx_classify #(.CW(CW)) u_cls (
    .ch    (rx_char),
    .codes (codes),
    .cls   (cls)
  );

  bsc_rx_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .valid    (rx_valid),
    .cls      (cls),
    .eot_hunt (cfg_eot_hunt),
    .crc_err  (crc_err_in),
    .d_store  (d_store),
    .d_crc    (d_crc),
    .d_chk    (d_chk),
    .d_fin    (d_fin),
    .d_hunt   (d_hunt),
    .d_code   (d_code)
  );

  bsc_rx_outreg #(.CW(CW)) u_out (
    .clk        (clk),
    .rst        (rst),
    .valid      (rx_valid),
    .ch         (rx_char),
    .d_store    (d_store),
    .d_crc      (d_crc),
    .d_chk      (d_chk),
    .d_fin      (d_fin),
    .d_hunt     (d_hunt),
    .d_code     (d_code),
    .out_valid  (out_valid),
    .out_char   (out_char),
    .out_crc_en (out_crc_en),
    .out_chk    (out_chk),
    .frame_end  (frame_end),
    .frame_code (frame_code),
    .hunt_req   (hunt_req),
    .crc_reset  (crc_reset)
  );
endmodule

// File: tb/test_bsc_rx_parser.sv
module test_bsc_rx_parser;
  localparam logic [7:0] SYN = 8'h16, DLE = 8'h10, STX = 8'h02, SOH = 8'h01,
    ETX = 8'h03, ETB = 8'h17, ITB = 8'h1F, ENQ = 8'h05, NAK = 8'h15,
    EOT = 8'h04, BEL = 8'h07;

  logic clk = 1'b0, rst = 1'b1, rx_valid = 1'b0;
  logic [7:0] rx_char = 8'h00, cfg_syn = SYN;
  logic eot_hunt = 1'b0, crc_err = 1'b0;
  logic out_valid, out_crc_en, out_chk, frame_end, hunt_req, crc_reset;
  logic [7:0] out_char, frame_code;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bsc_rx_parser i_bsc_rx_parser (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_char(rx_char),
    .cfg_syn(cfg_syn), .cfg_dle(DLE), .cfg_stx(STX), .cfg_soh(SOH),
    .cfg_etx(ETX), .cfg_etb(ETB), .cfg_itb(ITB), .cfg_enq(ENQ),
    .cfg_nak(NAK), .cfg_eot(EOT), .cfg_bel(BEL), .cfg_eot_hunt(eot_hunt),
    .crc_err_in(crc_err), .out_valid(out_valid), .out_char(out_char),
    .out_crc_en(out_crc_en), .out_chk(out_chk), .frame_end(frame_end),
    .frame_code(frame_code), .hunt_req(hunt_req), .crc_reset(crc_reset));

  function automatic logic [21:0] outs();
    return {out_valid, out_crc_en, out_chk, frame_end, hunt_req, crc_reset,
            frame_code, out_char};
  endfunction

  // One strobe, then compare all outputs one cycle later.
  task automatic step(input logic [7:0] c, input logic ev, ecrc, echk, eend,
                      ehunt, input logic [7:0] ecode, input string tag);
    logic [21:0] exp_v;
    @(negedge clk); rx_valid = 1'b1; rx_char = c;
    @(negedge clk); rx_valid = 1'b0;
    exp_v = {ev, ecrc, echk, eend, ehunt, eend, ecode, ev ? c : 8'h00};
    checks++;
    if (outs() !== exp_v) begin
      errors++;
      $display("FAIL %s char %h actual %h expected %h", tag, c, outs(), exp_v);
    end
  endtask

  task automatic st(input logic [7:0] c, input logic crc, input string tag);
    step(c, 1, crc, 0, 0, 0, 8'h00, tag);
  endtask
  task automatic dr(input logic [7:0] c, input string tag);
    step(c, 0, 0, 0, 0, 0, 8'h00, tag);
  endtask
  task automatic ck(input logic [7:0] c, input string tag);
    step(c, 1, 1, 1, 0, 0, 8'h00, tag);
  endtask
  task automatic en(input logic [7:0] c, input logic stored, input logic [7:0] code,
                    input string tag);
    step(c, stored, 0, 0, 1, 1, code, tag);
  endtask
  task automatic tail(input logic err, input string tag);
    crc_err = 1'b0;
    ck(8'hA1, tag); ck(8'hA2, tag); dr(8'h55, tag);
    crc_err = err;
    en(8'h55, 0, 8'h80 | (err ? 8'h40 : 8'h00), tag);
    crc_err = 1'b0;
  endtask

  function automatic bit is_nt_ctl(input logic [7:0] v);
    return v == SYN || v == ETX || v == ETB || v == ITB || v == ENQ;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (outs() !== 22'h0) begin
      errors++; $display("FAIL R1 reset actual %h expected 0", outs());
    end

    // R1 R3 R4 R5: plain text frame, good and bad CRC
    dr(SYN, "R1"); dr(SYN, "R1"); st(STX, 0, "R1"); st(8'h41, 1, "R4");
    dr(SYN, "R3"); st(8'h42, 1, "R4"); st(ETX, 1, "R5"); tail(0, "R5");
    st(STX, 0, "R1"); st(8'h43, 1, "R4"); st(ETB, 1, "R5"); tail(1, "R5");
    st(8'h5A, 0, "R1");

    // R3 R4: header into text
    st(SOH, 0, "R1"); dr(SYN, "R3"); st(8'h48, 1, "R4"); dr(SYN, "R3");
    st(8'h49, 1, "R4"); st(STX, 1, "R4"); st(8'h44, 1, "R4");
    st(ETB, 1, "R5"); tail(1, "R5");

    // R2: opening control characters
    en(NAK, 1, 8'h80, "R2"); en(ENQ, 1, 8'h80, "R2"); en(BEL, 1, 8'h80, "R2");
    en(EOT, 1, 8'h80, "R2");
    eot_hunt = 1'b1; step(EOT, 1, 0, 0, 0, 1, 8'h00, "R2"); eot_hunt = 1'b0;

    // R6
    st(STX, 0, "R6"); st(8'h61, 1, "R6"); en(ENQ, 1, 8'h80, "R6");

    // R7 R8: transparent text with escapes
    st(DLE, 0, "R9"); st(STX, 0, "R9"); st(8'h78, 1, "R7"); st(SYN, 1, "R7");
    dr(DLE, "R7"); st(DLE, 1, "R8"); dr(DLE, "R8"); dr(SYN, "R8");
    st(8'h79, 1, "R7"); dr(DLE, "R8"); st(ETX, 1, "R8"); tail(0, "R8");
    st(DLE, 0, "R8"); st(STX, 0, "R8"); dr(DLE, "R8"); en(ENQ, 1, 8'h80, "R8");
    st(DLE, 0, "R8"); st(STX, 0, "R8"); dr(DLE, "R8"); en(8'h71, 1, 8'h08, "R8");

    // R9
    st(DLE, 0, "R9"); en(8'h71, 1, 8'h80, "R9");
    st(SOH, 0, "R9"); st(DLE, 1, "R9"); en(8'h71, 1, 8'h08, "R9");
    st(SOH, 0, "R9"); st(8'h48, 1, "R9"); st(DLE, 1, "R9"); st(STX, 1, "R9");
    st(8'h7A, 1, "R9"); dr(DLE, "R9"); st(ETB, 1, "R9"); tail(0, "R9");

    // R10: intermediate checks in both modes
    st(STX, 0, "R10"); st(8'h61, 1, "R10"); st(ITB, 1, "R10"); ck(8'hB1, "R10");
    ck(8'hB2, "R10"); dr(SYN, "R10"); dr(SYN, "R10"); st(8'h62, 1, "R10");
    st(ETX, 1, "R10"); tail(0, "R10");
    st(DLE, 0, "R10"); st(STX, 0, "R10"); st(8'h63, 1, "R10"); dr(DLE, "R10");
    st(ITB, 1, "R10"); ck(8'hB3, "R10"); ck(8'hB4, "R10"); dr(SYN, "R10");
    st(DLE, 1, "R10"); st(STX, 1, "R10"); st(SYN, 1, "R10"); dr(DLE, "R10");
    st(ETB, 1, "R10"); tail(0, "R10");
    st(DLE, 0, "R10"); st(STX, 0, "R10"); dr(DLE, "R10"); st(ITB, 1, "R10");
    ck(8'hB5, "R10"); ck(8'hB6, "R10"); en(8'h64, 1, 8'h08, "R10");

    // R4 sweep: every non-control byte in plain text
    st(STX, 0, "R4");
    for (int v = 0; v < 256; v++)
      if (!is_nt_ctl(8'(v))) st(8'(v), 1, "R4");
    st(ETX, 1, "R4"); tail(0, "R4");

    // R7 sweep: every non-DLE byte in transparent text
    st(DLE, 0, "R7"); st(STX, 0, "R7");
    for (int v = 0; v < 256; v++)
      if (8'(v) != DLE) st(8'(v), 1, "R7");
    dr(DLE, "R7"); st(ETX, 1, "R7"); tail(0, "R7");

    // R12: remapped SYN
    cfg_syn = 8'h32;
    st(STX, 0, "R12"); st(SYN, 1, "R12"); dr(8'h32, "R12"); st(ETX, 1, "R12");
    tail(0, "R12");
    cfg_syn = SYN;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule